// File: doc/BRIEF.md
# Configurable Logic Cell with Carry

This block is a soft model of a single programmable logic element. A 4-input lookup table produces an arbitrary Boolean function of four user inputs. A fast carry stage, steered by that lookup result, gives a one-bit full-adder slice. A storage element can be set up as a level-sensitive latch or as a D, T, JK or SR flip-flop. A synchronous set/reset input loads the element with a value chosen by configuration.

All behaviour comes from a 21-bit configuration word. The word is loaded serially while the cell is running, one bit per clock while the shift enable is high, least significant bit first. Every bit shifted out appears on a serial output, so several cells can share one configuration stream. When the carry output of each cell drives the carry input of the next, and each cell is given the right function, a chain of cells forms a ripple-carry adder.

Configuration word layout, by bit index: bits 15..0 hold the truth table. Bits 18..16 hold the storage mode. Bit 19 holds the value that set/reset loads. Bit 20 is the output select.

Top module: `lcell_top`

## Requirements
- R1: `lut_out` equals configuration bit number {in_d,in_c,in_b,in_a}, with in_a as the least significant index bit, for every one of the 16 input combinations. Every function uses this same single selection path.
- R2: `carry_out` equals `carry_in` when `lut_out` is 1 and equals `in_a` when `lut_out` is 0; `sum_out` equals `lut_out` XOR `carry_in`.
- R3: On each clock with `cfg_shift_en` high, the configuration word shifts one place toward bit 0 and `cfg_din` enters bit 20. `cfg_dout` always shows the current bit 0, so 21 shifts load a word LSB first. With `cfg_shift_en` low the word is unchanged.
- R4: Mode code 000 (D): on a clock with `ce` high, the stored bit takes `lut_out`. Mode codes 101, 110 and 111 keep the stored bit unchanged.
- R5: Mode code 001 (T): on a clock with `ce` high, the stored bit inverts when `lut_out` is 1 and is kept when it is 0.
- R6: Mode code 010 (JK): J is `lut_out` and K is `in_d`. On a clock with `ce` high, 00 holds, J alone sets, K alone clears, and both together toggle.
- R7: Mode code 011 (SR): S is `lut_out` and R is `in_d`. On a clock with `ce` high, S alone sets, R alone clears, and none or both hold.
- R8: Mode code 100 (latch): while `ce` is high and neither `sr_in` nor `cfg_shift_en` is high, the storage output follows `lut_out` without delay. Otherwise it holds the value captured at the last clock edge where the gate was open.
- R9: A clock with `sr_in` high and `cfg_shift_en` low loads configuration bit 19 into the stored bit, whatever the state of `ce` and the mode.
- R10: While `cfg_shift_en` is high the stored bit keeps its value, even when `sr_in` or `ce` is high.
- R11: With configuration bit 20 at 1, `cell_out` shows the storage output; with it at 0, `cell_out` equals `lut_out`.
- R12: A clock edge with `rst_n` low clears the configuration word and the stored bit. Afterwards `cfg_dout`, `lut_out` and `cell_out` are 0.
- R13: N cells whose truth table is in_a XOR in_b (0x6666) form an N-bit ripple adder when each `carry_out` drives the next `carry_in` and the configuration outputs are chained into the next configuration inputs. The sums and the final carry then equal a + b + carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting and storage |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift_en | input | 1 | Shift the configuration word one place this clock |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output, for chaining |
| in_a | input | 1 | Lookup input, index bit 0, also the carry generate operand |
| in_b | input | 1 | Lookup input, index bit 1 |
| in_c | input | 1 | Lookup input, index bit 2 |
| in_d | input | 1 | Lookup input, index bit 3, also K or R in JK/SR modes |
| carry_in | input | 1 | Carry from the previous cell |
| sr_in | input | 1 | Synchronous set/reset request |
| ce | input | 1 | Clock enable, and latch gate in latch mode |
| lut_out | output | 1 | Combinational lookup result |
| sum_out | output | 1 | Sum bit |
| carry_out | output | 1 | Carry to the next cell |
| cell_out | output | 1 | Storage output or lookup result, by output select |

## Verification
A random truth table is swept through all sixteen input combinations. This separates a correct index order from a swapped or reversed one. Random carry and input patterns drive the carry stage with lookup results of both polarities, so a swapped mux select shows up. Each storage mode is run under random enable, set/reset and function inputs against the bench's own cycle model. This tells apart the JK toggle from the SR hold and the latch's transparency from an edge-triggered capture. A chain of four cells then adds random operands, which exposes faults in both the carry path and the serial configuration chaining.

// File: rtl/lcell_pkg.sv
// Shared constants and types for the configurable logic cell.
// Assumes a 4-input lookup table; the word layout is derived from it.
package lcell_pkg;
    localparam int LUT_K    = 4;
    localparam int LUT_BITS = 1 << LUT_K;
    localparam int MODE_W   = 3;
    localparam int MODE_LSB = LUT_BITS;
    localparam int SRV_BIT  = MODE_LSB + MODE_W;
    localparam int OSEL_BIT = SRV_BIT + 1;
    localparam int CFG_W    = OSEL_BIT + 1;

    typedef enum logic [MODE_W-1:0] {
        SM_D     = 3'b000,
        SM_T     = 3'b001,
        SM_JK    = 3'b010,
        SM_SR    = 3'b011,
        SM_LATCH = 3'b100
    } stor_mode_e;
endpackage

// File: rtl/lcell_cfg_chain.sv
// Serial configuration register: shifts toward bit 0 when enabled,
// new bit enters at the top, bit 0 is the chain output.
// Assumes a synchronous active-low reset that clears the word.
module lcell_cfg_chain #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic             dout,
    output logic [WIDTH-1:0] cfg
);
    // Shift register holding the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg <= '0;
        else if (shift_en) cfg <= {din, cfg[WIDTH-1:1]};
    end

    assign dout = cfg[0];

    a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg[WIDTH-1] == $past(din)) && (cfg[WIDTH-2:0] == $past(cfg[WIDTH-1:1])));
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg));
endmodule

// File: rtl/lcell_lut.sv
// Lookup table: a mux tree picks one stored bit using the select inputs.
// Every function passes the same number of mux levels.
module lcell_lut #(
    parameter int K = 4,
    localparam int N = 1 << K
) (
    input  logic [N-1:0] table_bits,
    input  logic [K-1:0] sel,
    output logic         y
);
    // Level l holds N>>l nodes; level 0 is the stored table.
    logic [N-1:0] lvl [0:K];
    assign lvl[0] = table_bits;

    genvar l, n;
    generate
        for (l = 0; l < K; l++) begin : g_lvl
            for (n = 0; n < (N >> (l + 1)); n++) begin : g_node
                assign lvl[l+1][n] = sel[l] ? lvl[l][2*n+1] : lvl[l][2*n];
            end
            if ((N >> (l + 1)) < N) begin : g_pad
                assign lvl[l+1][N-1:(N >> (l + 1))] = '0;
            end
        end
    endgenerate

    assign y = lvl[K][0];
endmodule

// File: rtl/lcell_carry.sv
// Carry stage: the lookup result steers a 2:1 mux between carry-in
// and the generate operand; the sum is lookup XOR carry-in.
module lcell_carry (
    input  logic prop,
    input  logic gen,
    input  logic cin,
    output logic sum,
    output logic cout
);
    assign cout = prop ? cin : gen;
    assign sum  = prop ^ cin;
endmodule

// File: rtl/lcell_store.sv
// Mode-selectable storage element: D, T, JK, SR flip-flop or a latch
// emulated on the clock (transparent while the gate is open).
// Priority: reset, configuration hold, set/reset, clock enable.
module lcell_store
    import lcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       sr,
    input  logic       sr_val,
    input  logic       ce,
    input  stor_mode_e mode,
    input  logic       fn,
    input  logic       aux,
    output logic       q_view
);
    logic q;
    logic nxt;

    // Next-state function for the configured mode.
    always_comb begin
        case (mode)
            SM_D:     nxt = fn;
            SM_T:     nxt = q ^ fn;
            SM_JK: begin
                case ({fn, aux})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    2'b11:   nxt = ~q;
                    default: nxt = q;
                endcase
            end
            SM_SR: begin
                case ({fn, aux})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    default: nxt = q;
                endcase
            end
            SM_LATCH: nxt = fn;
            default:  nxt = q;
        endcase
    end

    // State register with its priority chain.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (hold) q <= q;
        else if (sr)   q <= sr_val;
        else if (ce)   q <= nxt;
    end

    // Latch transparency bypasses the register while the gate is open.
    assign q_view = (mode == SM_LATCH && ce && !sr && !hold) ? fn : q;

    a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q));
    a_r9_sr_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && sr) |=> (q == $past(sr_val)));
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_T && ce && fn && !sr && !hold) |=> (q != $past(q)));
    a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_SR && ce && fn && aux && !sr && !hold) |=> $stable(q));
    a_r6_jk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_JK && ce && fn && aux && !sr && !hold) |=> (q != $past(q)));
endmodule

// File: rtl/lcell_top.sv
// Configurable logic cell: serial configuration, 4-input lookup table,
// carry stage and mode-selectable storage with an output select.
// Assumes one clock for configuration and user logic.
module lcell_top
    import lcell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_shift_en,
    input  logic cfg_din,
    output logic cfg_dout,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    input  logic in_d,
    input  logic carry_in,
    input  logic sr_in,
    input  logic ce,
    output logic lut_out,
    output logic sum_out,
    output logic carry_out,
    output logic cell_out
);
    logic [CFG_W-1:0] cfg;
    logic             q_view;
    stor_mode_e       mode;

    lcell_cfg_chain #(.WIDTH(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (cfg_din),
        .dout     (cfg_dout),
        .cfg      (cfg)
    );

    lcell_lut #(.K(LUT_K)) u_lut (
        .table_bits (cfg[LUT_BITS-1:0]),
        .sel        ({in_d, in_c, in_b, in_a}),
        .y          (lut_out)
    );

    lcell_carry u_carry (
        .prop (lut_out),
        .gen  (in_a),
        .cin  (carry_in),
        .sum  (sum_out),
        .cout (carry_out)
    );

    assign mode = stor_mode_e'(cfg[MODE_LSB +: MODE_W]);

    lcell_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (cfg_shift_en),
        .sr     (sr_in),
        .sr_val (cfg[SRV_BIT]),
        .ce     (ce),
        .mode   (mode),
        .fn     (lut_out),
        .aux    (in_d),
        .q_view (q_view)
    );

    // Output select between storage and the combinational result.
    assign cell_out = cfg[OSEL_BIT] ? q_view : lut_out;

    a_r2_carry_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a == carry_in) |-> (carry_out == in_a));
    a_r11_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[OSEL_BIT] |-> (cell_out == lut_out));
endmodule

// File: tb/tb_lcell_top.sv
// Self-checking bench: behavioural model compared every cycle,
// directed checks for set/reset, hold and reset, and a 4-cell adder.
module tb_lcell_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shift_en = 1'b0, cfg_din = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, in_d = 1'b0;
    logic carry_in = 1'b0, sr_in = 1'b0, ce = 1'b0;
    logic cfg_dout, lut_out, sum_out, carry_out, cell_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 1'b0;

    always #10 clk = ~clk;

    lcell_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .carry_in(carry_in), .sr_in(sr_in), .ce(ce), .lut_out(lut_out),
        .sum_out(sum_out), .carry_out(carry_out), .cell_out(cell_out)
    );

    // Four-cell adder chain.
    localparam int NC = 4;
    logic          ch_shift = 1'b0, ch_din = 1'b0, ch_cin = 1'b0;
    logic [NC-1:0] ch_a = '0, ch_b = '0;
    logic [NC-1:0] ch_sum, ch_cout, ch_cdout, ch_lut, ch_cell;
    logic [NC:0]   ch_c;
    logic [NC:0]   ch_cfgc;
    assign ch_c[0]    = ch_cin;
    assign ch_cfgc[0] = ch_din;

    for (genvar i = 0; i < NC; i++) begin : g_cell
        lcell_top u_c (
            .clk(clk), .rst_n(rst_n), .cfg_shift_en(ch_shift), .cfg_din(ch_cfgc[i]),
            .cfg_dout(ch_cdout[i]), .in_a(ch_a[i]), .in_b(ch_b[i]), .in_c(1'b0),
            .in_d(1'b0), .carry_in(ch_c[i]), .sr_in(1'b0), .ce(1'b0),
            .lut_out(ch_lut[i]), .sum_out(ch_sum[i]), .carry_out(ch_cout[i]),
            .cell_out(ch_cell[i])
        );
        assign ch_c[i+1]    = ch_cout[i];
        assign ch_cfgc[i+1] = ch_cdout[i];
    end

    // Reference model state.
    logic [20:0] m_cfg = '0;
    logic        m_q   = 1'b0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    function automatic logic m_lut();
        int idx;
        idx = in_a + 2 * in_b + 4 * in_c + 8 * in_d;
        return m_cfg[idx];
    endfunction

    // Model update at each edge, from the inputs present before it.
    always @(posedge clk) begin
        logic f;
        int   md;
        f  = m_lut();
        md = m_cfg[18:16];
        if (!rst_n) begin
            m_cfg = '0;
            m_q   = 1'b0;
        end else begin
            if (!cfg_shift_en) begin
                if (sr_in) m_q = m_cfg[19];
                else if (ce) begin
                    if (md == 0 || md == 4) m_q = f;
                    else if (md == 1) begin if (f) m_q = !m_q; end
                    else if (md == 2) begin
                        if (f && in_d) m_q = !m_q;
                        else if (f) m_q = 1'b1;
                        else if (in_d) m_q = 1'b0;
                    end else if (md == 3) begin
                        if (f && !in_d) m_q = 1'b1;
                        else if (!f && in_d) m_q = 1'b0;
                    end
                end
            end
            if (cfg_shift_en) m_cfg = {cfg_din, m_cfg[20:1]};
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        logic f, ecell;
        int   md;
        if (chk_on) begin
            f  = m_lut();
            md = m_cfg[18:16];
            chk("R1 lut_out", lut_out, f);
            chk("R2 carry_out", carry_out, f ? carry_in : in_a);
            chk("R2 sum_out", sum_out, f ^ carry_in);
            chk("R3 cfg_dout", cfg_dout, m_cfg[0]);
            if (!m_cfg[20]) chk("R11 cell_out", cell_out, f);
            else begin
                ecell = (md == 4 && ce && !sr_in && !cfg_shift_en) ? f : m_q;
                case (md)
                    0:       chk("R4 cell_out D", cell_out, ecell);
                    1:       chk("R5 cell_out T", cell_out, ecell);
                    2:       chk("R6 cell_out JK", cell_out, ecell);
                    3:       chk("R7 cell_out SR", cell_out, ecell);
                    4:       chk("R8 cell_out latch", cell_out, ecell);
                    default: chk("R4 cell_out reserved", cell_out, ecell);
                endcase
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [20:0] w, input bit noisy);
        for (int i = 0; i < 21; i++) begin
            cfg_shift_en = 1'b1;
            cfg_din      = w[i];
            if (noisy) begin
                sr_in = 1'($urandom_range(0, 1));
                ce    = 1'($urandom_range(0, 1));
            end
            tick();
        end
        cfg_shift_en = 1'b0;
        sr_in        = 1'b0;
        tick();
    endtask

    task automatic drive_rand(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            {in_d, in_c, in_b, in_a} = 4'($urandom);
            carry_in = 1'($urandom);
            ce       = 1'($urandom);
            sr_in    = ($urandom_range(0, 7) == 0);
            tick();
        end
        sr_in = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] exp5;
        logic [4:0] act5;
        logic [3:0] a4, b4;
        logic       c1;
        // R12: reset state.
        repeat (2) tick();
        rst_n = 1'b1;
        #8;
        chk("R12 cfg_dout after reset", cfg_dout, 1'b0);
        chk("R12 lut_out after reset", lut_out, 1'b0);
        chk("R12 cell_out after reset", cell_out, 1'b0);
        tick();
        chk_on = 1'b1;

        // R1: random truth table, full sweep, combinational output.
        load({2'b00, 3'b000, 16'($urandom)}, 1'b0);
        for (int v = 0; v < 16; v++) begin
            {in_d, in_c, in_b, in_a} = 4'(v);
            carry_in = 1'($urandom);
            tick();
        end
        // R2 and R3: random patterns while a new word streams through.
        load({1'b1, 1'b0, 3'b000, 16'hA5C3}, 1'b0);
        drive_rand(40);

        // Storage modes R4..R8 and reserved codes, set/reset value 0 and 1.
        for (int md = 0; md < 8; md++) begin
            for (int sv = 0; sv < 2; sv++) begin
                load({1'b1, 1'(sv), 3'(md), 16'($urandom)}, 1'b1);
                drive_rand(50);
            end
        end

        // R9: set/reset acts with ce low and overrides the function.
        load({1'b1, 1'b0, 3'b000, 16'hFFFF}, 1'b0);
        ce = 1'b1; tick(); ce = 1'b0;
        #8 chk("R9 D captures 1 before clear", cell_out, 1'b1);
        tick();
        sr_in = 1'b1; ce = 1'b0; tick(); sr_in = 1'b0;
        #8 chk("R9 clear with ce low", cell_out, 1'b0);
        tick();
        load({1'b1, 1'b1, 3'b000, 16'h0000}, 1'b0);
        sr_in = 1'b1; ce = 1'b1; tick(); sr_in = 1'b0; ce = 1'b0;
        #8 chk("R9 set beats ce", cell_out, 1'b1);
        tick();

        // R10: stored 0 kept while shifting ones with sr and ce high.
        load({1'b1, 1'b1, 3'b000, 16'h0000}, 1'b0);
        ce = 1'b1; tick();
        #8 chk("R10 stored 0 before shift", cell_out, 1'b0);
        tick();
        cfg_shift_en = 1'b1; cfg_din = 1'b1; sr_in = 1'b1; ce = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            #8 chk("R10 held during shift", cell_out, 1'b0);
        end
        tick();
        cfg_shift_en = 1'b0; sr_in = 1'b0; ce = 1'b0;
        tick();

        // R12: reset mid-run clears everything.
        load({1'b1, 1'b1, 3'b001, 16'hFFFF}, 1'b0);
        sr_in = 1'b1; tick(); sr_in = 1'b0;
        chk_on = 1'b0;
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        {in_d, in_c, in_b, in_a} = 4'hF;
        #8;
        chk("R12 cfg_dout after mid reset", cfg_dout, 1'b0);
        chk("R12 lut_out after mid reset", lut_out, 1'b0);
        chk("R12 cell_out after mid reset", cell_out, 1'b0);
        tick();

        // R13: four chained cells as a ripple adder.
        for (int c = 0; c < NC; c++) begin
            for (int i = 0; i < 21; i++) begin
                ch_shift = 1'b1;
                ch_din   = ((21'h006666 >> i) & 1) != 0;
                tick();
            end
        end
        ch_shift = 1'b0;
        tick();
        for (int v = 0; v < 64; v++) begin
            a4 = 4'($urandom); b4 = 4'($urandom); c1 = 1'($urandom);
            ch_a = a4; ch_b = b4; ch_cin = c1;
            #8;
            exp5 = 5'(a4) + 5'(b4) + 5'(c1);
            act5 = {ch_c[NC], ch_sum};
            n_tests++;
            if (act5 !== exp5) begin
                n_fail++;
                $display("FAIL R13 adder %0d+%0d+%0d: actual=%0d expected=%0d",
                         a4, b4, c1, act5, exp5);
            end
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule